// File: doc/BRIEF.md
# Microprogram Address Sequencer

This block produces the address of the next microinstruction for a microcoded controller. A registered program counter drives the control-store address. Every microinstruction supplies a 3-bit next-address operation and a test bit, and the block uses them to pick the following address. The choices are an increment, a skip, a jump, a subroutine call or return, and a loop start or loop end. An external branch address is loaded on taken jumps and calls. That address can come from a constant field or from a datapath result.

A single shallow return stack serves both subroutine calls and loops. Its level is visible on full and empty outputs. One-cycle flags report a push that went into a full stack and a pop that was taken from an empty one. The control-store memories are outside this block.

Top module: `useq_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next address is 0, the stack becomes empty (`stk_empty`=1, `stk_full`=0), and both event flags are 0.
- R2: Operation code 7 (restart) loads address 0 whatever `test` is, and leaves the stack unchanged.
- R3: Operation code 1 (step) loads address+1, and the count wraps modulo 1024, so 1023 is followed by 0.
- R4: Operation code 0 (skip) loads address+2 when `test`=1 and address+1 when `test`=0.
- R5: Operation code 5 (loop start) pushes the current address onto the stack and loads address+1.
- R6: Operation code 2 (loop end) always pops the stack. With `test`=1 the popped value becomes the address. With `test`=0 the popped value is discarded and the address becomes address+1.
- R7: Operation code 4 (call) with `test`=1 pushes address+1 and loads `branch_addr`. With `test`=0 it loads address+1 and leaves the stack unchanged.
- R8: Operation code 3 (return) pops the stack top into the address.
- R9: Operation code 6 (jump) loads `branch_addr` when `test`=1 and address+1 when `test`=0.
- R10: The stack holds 4 entries. `stk_full` is 1 at 4 entries and `stk_empty` is 1 at 0 entries.
- R11: A push into a full stack discards the oldest entry, keeps the newest 4, and sets `stk_ovf` for exactly the following cycle.
- R12: A pop from an empty stack yields the value that was last at the bottom of the stack (0 after reset), and sets `stk_unf` for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_op | input | 3 | Next-address operation code |
| test | input | 1 | Condition bit for conditional operations |
| branch_addr | input | 10 | Target for jumps and calls |
| uaddr | output | 10 | Registered microinstruction address |
| stk_full | output | 1 | Stack holds 4 entries |
| stk_empty | output | 1 | Stack holds no entries |
| stk_ovf | output | 1 | A push into a full stack happened last cycle |
| stk_unf | output | 1 | A pop from an empty stack happened last cycle |

## Verification
The bench targets the 1023-to-0 wrap, which a design with a wider or saturating counter would get wrong. It also checks the loop-end case with the test bit low: a design that forgot to discard the top would leave a stale entry and return to the wrong address later. Calls are checked to push address+1, because pushing the call address itself would make every return re-run the call. The bench fills the stack past its depth and then pops it past empty. A design that dropped the newest entry on overflow, or returned garbage on underflow, would return to the wrong address.

// File: rtl/useq_pkg.sv
package useq_pkg;
  typedef enum logic [2:0] {
    OP_SKIP    = 3'd0,
    OP_STEP    = 3'd1,
    OP_LOOPEND = 3'd2,
    OP_RET     = 3'd3,
    OP_CALL    = 3'd4,
    OP_LOOPBEG = 3'd5,
    OP_JUMP    = 3'd6,
    OP_RESTART = 3'd7
  } nxt_op_e;
endpackage

// File: rtl/useq_stack.sv
module useq_stack #(
  parameter int AW    = 10,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] push_data,
  output logic [AW-1:0] top_data,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          unf
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] ent [DEPTH];
  logic [CW-1:0] cnt;

  assign top_data = ent[0];
  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);

  // Entry 0 is the top; a pop copies the bottom entry so it persists.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
        if (rst) begin
          ent[i] <= '0;
        end else if (push) begin
          if (i == 0) ent[i] <= push_data;
          else        ent[i] <= ent[i-1];
        end else if (pop) begin
          if (i == DEPTH-1) ent[i] <= ent[i];
          else              ent[i] <= ent[i+1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      ovf <= push && full;
      unf <= pop && empty;
      if (push && !full)      cnt <= cnt + CW'(1);
      else if (pop && !empty) cnt <= cnt - CW'(1);
    end
  end

  assert_level_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  assert_ovf_flag_R11: assert property (@(posedge clk) disable iff (rst)
    (push && full) |=> ovf);
  assert_unf_flag_R12: assert property (@(posedge clk) disable iff (rst)
    (pop && empty) |=> unf);
endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [2:0]    op,
  input  logic          test,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] branch,
  input  logic [AW-1:0] stk_top,
  output logic [AW-1:0] nxt_pc,
  output logic          push,
  output logic          pop,
  output logic [AW-1:0] push_data
);
  logic [AW-1:0] inc1;
  nxt_op_e       opc;

  assign inc1 = pc + AW'(1);
  assign opc  = nxt_op_e'(op);

  always_comb begin
    nxt_pc    = inc1;
    push      = 1'b0;
    pop       = 1'b0;
    push_data = pc;
    unique case (opc)
      OP_SKIP:    nxt_pc = test ? pc + AW'(2) : inc1;
      OP_STEP:    nxt_pc = inc1;
      OP_LOOPEND: begin
        pop    = 1'b1;
        nxt_pc = test ? stk_top : inc1;
      end
      OP_RET: begin
        pop    = 1'b1;
        nxt_pc = stk_top;
      end
      OP_CALL: begin
        push      = test;
        push_data = inc1;
        nxt_pc    = test ? branch : inc1;
      end
      OP_LOOPBEG: begin
        push      = 1'b1;
        push_data = pc;
      end
      OP_JUMP:    nxt_pc = test ? branch : inc1;
      OP_RESTART: nxt_pc = '0;
      default:    nxt_pc = inc1;
    endcase
  end
endmodule

// File: rtl/useq_addr_gen.sv
module useq_addr_gen #(
  parameter int AW    = 10,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    nxt_op,
  input  logic          test,
  input  logic [AW-1:0] branch_addr,
  output logic [AW-1:0] uaddr,
  output logic          stk_full,
  output logic          stk_empty,
  output logic          stk_ovf,
  output logic          stk_unf
);
  logic [AW-1:0] pc, nxt_pc, stk_top, push_data;
  logic          push, pop;

  useq_next #(.AW(AW)) u_next (
    .op(nxt_op), .test(test), .pc(pc), .branch(branch_addr),
    .stk_top(stk_top), .nxt_pc(nxt_pc), .push(push), .pop(pop),
    .push_data(push_data)
  );

  useq_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .push_data(push_data),
    .top_data(stk_top), .full(stk_full), .empty(stk_empty),
    .ovf(stk_ovf), .unf(stk_unf)
  );

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= nxt_pc;
  end

  assign uaddr = pc;

  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (nxt_op == 3'd7) |=> (uaddr == '0));
  assert_step_inc_R3: assert property (@(posedge clk) disable iff (rst)
    (nxt_op == 3'd1) |=> (uaddr == $past(uaddr) + AW'(1)));
  assert_skip_two_R4: assert property (@(posedge clk) disable iff (rst)
    (nxt_op == 3'd0 && test) |=> (uaddr == $past(uaddr) + AW'(2)));
  assert_jump_load_R9: assert property (@(posedge clk) disable iff (rst)
    (nxt_op == 3'd6 && test) |=> (uaddr == $past(branch_addr)));
endmodule

// File: tb/tb_useq_addr_gen.sv
module tb_useq_addr_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] nxt_op = 3'd1;
  logic       test = 1'b0;
  logic [9:0] branch_addr = '0;
  logic [9:0] uaddr;
  logic       stk_full, stk_empty, stk_ovf, stk_unf;

  always #2.5 clk = ~clk;

  useq_addr_gen dut (
    .clk(clk), .rst(rst), .nxt_op(nxt_op), .test(test),
    .branch_addr(branch_addr), .uaddr(uaddr), .stk_full(stk_full),
    .stk_empty(stk_empty), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
  );

  typedef struct {
    logic [9:0] addr;
    logic full, empty, ovf, unf;
    string rq;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  logic [9:0] m_pc;
  logic [9:0] m_stk [4];
  int m_cnt;

  task automatic m_push(input logic [9:0] v);
    for (int i = 3; i > 0; i--) m_stk[i] = m_stk[i-1];
    m_stk[0] = v;
    if (m_cnt < 4) m_cnt++;
  endtask

  task automatic m_pop(output logic [9:0] v);
    v = m_stk[0];
    for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i+1];
    if (m_cnt > 0) m_cnt--;
  endtask

  task automatic step(input logic [2:0] op, input logic t,
                      input logic [9:0] b, input string rq);
    exp_t e;
    logic [9:0] v;
    bit o = 0, u = 0;
    @(negedge clk);
    nxt_op = op; test = t; branch_addr = b;
    case (op)
      3'd0: m_pc = t ? m_pc + 10'd2 : m_pc + 10'd1;
      3'd1: m_pc = m_pc + 10'd1;
      3'd2: begin u = (m_cnt == 0); m_pop(v); m_pc = t ? v : m_pc + 10'd1; end
      3'd3: begin u = (m_cnt == 0); m_pop(v); m_pc = v; end
      3'd4: if (t) begin o = (m_cnt == 4); m_push(m_pc + 10'd1); m_pc = b; end
            else m_pc = m_pc + 10'd1;
      3'd5: begin o = (m_cnt == 4); m_push(m_pc); m_pc = m_pc + 10'd1; end
      3'd6: m_pc = t ? b : m_pc + 10'd1;
      default: m_pc = '0;
    endcase
    e.addr = m_pc; e.full = (m_cnt == 4); e.empty = (m_cnt == 0);
    e.ovf = o; e.unf = u; e.rq = rq;
    q.push_back(e);
  endtask

  // Monitor: compares one expected item per clock edge
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (uaddr !== e.addr || stk_full !== e.full || stk_empty !== e.empty ||
            stk_ovf !== e.ovf || stk_unf !== e.unf) begin
          fails++;
          $display("FAIL %s: got addr=%0d f=%b e=%b o=%b u=%b exp addr=%0d f=%b e=%b o=%b u=%b",
                   e.rq, uaddr, stk_full, stk_empty, stk_ovf, stk_unf,
                   e.addr, e.full, e.empty, e.ovf, e.unf);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang exp finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_pc = '0; m_cnt = 0;
    for (int i = 0; i < 4; i++) m_stk[i] = '0;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 reset state
    if (uaddr !== 10'd0 || stk_empty !== 1'b1 || stk_full !== 1'b0 ||
        stk_ovf !== 1'b0 || stk_unf !== 1'b0) begin
      fails++;
      $display("FAIL R1: got addr=%0d e=%b f=%b exp addr=0 e=1 f=0", uaddr, stk_empty, stk_full);
    end
    @(negedge clk); rst = 1'b0;
    // R12 underflow right after reset returns 0
    step(3'd3, 1'b0, 10'd0, "R12");
    step(3'd1, 1'b0, 10'd0, "R3");
    step(3'd1, 1'b1, 10'd0, "R3");
    step(3'd0, 1'b1, 10'd0, "R4");
    step(3'd0, 1'b0, 10'd0, "R4");
    step(3'd6, 1'b0, 10'd77, "R9");
    step(3'd6, 1'b1, 10'd1022, "R9");
    step(3'd1, 1'b0, 10'd0, "R3");
    step(3'd1, 1'b0, 10'd0, "R3");   // 1023 -> 0
    step(3'd0, 1'b1, 10'd0, "R4");
    step(3'd7, 1'b1, 10'd0, "R2");
    // loop start then loop end both ways
    step(3'd5, 1'b0, 10'd0, "R5");
    step(3'd1, 1'b0, 10'd0, "R5");
    step(3'd2, 1'b1, 10'd0, "R6");
    step(3'd5, 1'b0, 10'd0, "R5");
    step(3'd2, 1'b0, 10'd0, "R6");
    // call / return
    step(3'd4, 1'b0, 10'd300, "R7");
    step(3'd4, 1'b1, 10'd300, "R7");
    step(3'd1, 1'b0, 10'd0, "R7");
    step(3'd3, 1'b0, 10'd0, "R8");
    // fill and overflow
    step(3'd6, 1'b1, 10'd500, "R9");
    for (int k = 0; k < 4; k++) step(3'd4, 1'b1, 10'(100 + 50*k), "R10");
    step(3'd7, 1'b0, 10'd0, "R2");
    step(3'd5, 1'b0, 10'd0, "R11");
    step(3'd1, 1'b0, 10'd0, "R11");
    for (int k = 0; k < 6; k++) step(3'd3, 1'b0, 10'd0, "R12");
    step(3'd2, 1'b1, 10'd0, "R12");
    step(3'd1, 1'b0, 10'd0, "R10");
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule